// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block sits beside one core's load/store path and decides whether a conditional store may go to memory. An exclusive load records a reservation on the 16-byte granule that holds its address. A later conditional store is compared against that reservation. A match lets the store through and reports success. A mismatch, or a store with no reservation, is dropped and reports status 0. Either outcome ends the reservation.

An explicit clear command ends a reservation without touching memory. Atomic swaps and ordinary loads and stores go to memory without any check and leave the reservation as it was. Consecutive conditional-store failures are counted. Each time the count reaches a nonzero multiple of a set period (100000 by default), the block raises a one-cycle livelock alert tagged with the core's context number.

Requests arrive one per cycle on a valid/opcode/address input. Every result appears on registered outputs one cycle later.

Top module: `excl_monitor`

## Requirements
- R1: After synchronous reset, all outputs are low, no reservation is held and the failure count is zero, so a conditional store straight after reset fails.
- R2: An exclusive load (opcode 2) is issued to memory and records bits [ADDR_W-1:4] of its address as the reservation, with the reservation valid. Bits [3:0] take no part in later matching.
- R3: A conditional store (opcode 3) with a valid reservation and an equal granule is issued to memory, reports stx_ok=1, clears the reservation and resets the failure count to zero.
- R4: A conditional store that fails is not issued to memory, reports stx_ok=0 and clears the reservation.
- R5: A swap (opcode 4) is always issued to memory and neither uses nor changes the reservation.
- R6: A clear command (opcode 5) clears the reservation and is not issued to memory.
- R7: Plain loads (opcode 0) and plain stores (opcode 1) are issued unchanged and do not affect the reservation.
- R8: A new exclusive load replaces any earlier reservation address.
- R9: Each failed conditional store adds one to the failure count. When the new count is a nonzero multiple of ALERT_PERIOD, alert is high for exactly one cycle and alert_ctx carries ctx_id as it was sampled with that request.
- R10: The failure count stops at 2^CNT_W-1 and does not wrap. While it is held there, no further alert is raised.
- R11: Every output is valid one cycle after its request. A cycle with req_valid low, or with a reserved opcode (6 or 7), produces no memory issue and no status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_id | input | CTX_W | Context number of this core |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Opcode: 0 load, 1 store, 2 exclusive load, 3 conditional store, 4 swap, 5 clear |
| req_addr | input | ADDR_W | Physical address |
| mem_valid | output | 1 | Request forwarded to memory |
| mem_op | output | 3 | Opcode of the forwarded request |
| mem_addr | output | ADDR_W | Address of the forwarded request |
| stx_done | output | 1 | A conditional store finished |
| stx_ok | output | 1 | 1 on success, 0 on failure (valid with stx_done) |
| alert | output | 1 | One-cycle livelock alert |
| alert_ctx | output | CTX_W | Context number that goes with the alert |

## Verification
Every output is registered, so the bench changes inputs on the falling edge and checks the results at the next falling edge. That is exactly one rising edge after the request. Any reservation change made by a request is seen by the request in the following cycle. The alert comes out in the same cycle as the status of the failing store that reached the multiple. The bench's reference model updates its reservation and counter state after each step's expectation is computed, which reproduces this one-cycle ordering.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LDEX  = 3'd2,
        OP_STEX  = 3'd3,
        OP_SWAP  = 3'd4,
        OP_CLREX = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    localparam int GRAN_BITS = 4;

    typedef struct packed {
        logic issue;
        logic set_resv;
        logic clr_resv;
        logic stx_done;
        logic stx_ok;
        logic fail;
    } verdict_t;

    function automatic logic passes_freely(op_e op);
        return (op == OP_LOAD) || (op == OP_STORE) ||
               (op == OP_LDEX) || (op == OP_SWAP);
    endfunction

endpackage

// File: rtl/excl_resv_reg.sv
module excl_resv_reg
    import excl_mon_pkg::*;
#(
    parameter int TAG_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             hit_o
);

    logic             flag_q;
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            tag_q  <= '0;
        end else if (set_i) begin
            flag_q <= 1'b1;
            tag_q  <= tag_i;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign hit_o = flag_q && (tag_i == tag_q);

    a_r2_set_records: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q && (tag_q == $past(tag_i)));

    a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/excl_fail_ctr.sv
module excl_fail_ctr
    import excl_mon_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PERIOD = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic fail_i,
    input  logic pass_i,
    output logic alert_o
);

    localparam int               PH_W    = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PH_W-1:0]  ph_q;
    logic             alert_q;
    logic             bump;

    assign bump = fail_i && (cnt_q != CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ph_q    <= '0;
            alert_q <= 1'b0;
        end else begin
            alert_q <= bump && (ph_q == PH_LAST);
            if (pass_i) begin
                cnt_q <= '0;
                ph_q  <= '0;
            end else if (bump) begin
                cnt_q <= cnt_q + 1'b1;
                ph_q  <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
            end
        end
    end

    assign alert_o = alert_q;

    a_r10_hold_at_max: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !pass_i) |=> cnt_q == CNT_MAX);

    a_r9_alert_needs_fail: assert property (@(posedge clk) disable iff (rst)
        alert_q |-> $past(fail_i));

    generate
        if (PERIOD > 1) begin : g_gap
            a_r9_alert_single: assert property (@(posedge clk) disable iff (rst)
                alert_q |=> !alert_q);
        end
    endgenerate

endmodule

// File: rtl/excl_decide.sv
module excl_decide
    import excl_mon_pkg::*;
(
    input  logic     req_valid,
    input  op_e      req_op,
    input  logic     hit,
    output verdict_t verdict
);

    always_comb begin
        verdict = '0;
        if (req_valid) begin
            if (passes_freely(req_op)) begin
                verdict.issue = 1'b1;
            end
            unique case (req_op)
                OP_LDEX:  verdict.set_resv = 1'b1;
                OP_STEX: begin
                    verdict.clr_resv = 1'b1;
                    verdict.stx_done = 1'b1;
                    verdict.stx_ok   = hit;
                    verdict.issue    = hit;
                    verdict.fail     = !hit;
                end
                OP_CLREX: verdict.clr_resv = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int CTX_W        = 8,
    parameter int CNT_W        = 32,
    parameter int ALERT_PERIOD = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTX_W-1:0]  ctx_id,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              mem_valid,
    output logic [2:0]        mem_op,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              stx_done,
    output logic              stx_ok,
    output logic              alert,
    output logic [CTX_W-1:0]  alert_ctx
);

    localparam int TAG_W = ADDR_W - GRAN_BITS;

    op_e      op;
    logic     hit;
    verdict_t vd;

    assign op = op_e'(req_op);

    excl_resv_reg #(.TAG_W(TAG_W)) u_resv (
        .clk   (clk),
        .rst   (rst),
        .set_i (vd.set_resv),
        .clr_i (vd.clr_resv),
        .tag_i (req_addr[ADDR_W-1:GRAN_BITS]),
        .hit_o (hit)
    );

    excl_decide u_decide (
        .req_valid (req_valid),
        .req_op    (op),
        .hit       (hit),
        .verdict   (vd)
    );

    excl_fail_ctr #(.CNT_W(CNT_W), .PERIOD(ALERT_PERIOD)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .fail_i  (vd.fail),
        .pass_i  (vd.stx_ok),
        .alert_o (alert)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            mem_op    <= '0;
            mem_addr  <= '0;
            stx_done  <= 1'b0;
            stx_ok    <= 1'b0;
            alert_ctx <= '0;
        end else begin
            mem_valid <= vd.issue;
            mem_op    <= req_op;
            mem_addr  <= req_addr;
            stx_done  <= vd.stx_done;
            stx_ok    <= vd.stx_ok;
            alert_ctx <= ctx_id;
        end
    end

    a_r4_fail_not_issued: assert property (@(posedge clk) disable iff (rst)
        (stx_done && !stx_ok) |-> !mem_valid);

    a_r3_pass_issued: assert property (@(posedge clk) disable iff (rst)
        (stx_done && stx_ok) |-> (mem_valid && mem_op == 3'd3));

    a_r6_clear_not_issued: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd5) |=> !mem_valid);

    a_r11_load_latency: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd0) |=> (mem_valid && mem_addr == $past(req_addr)));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!mem_valid && !stx_done));

endmodule

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;

    localparam int AW  = 32;
    localparam int CW  = 4;
    localparam int NW  = 4;
    localparam int PER = 5;
    localparam int MAXC = (1 << NW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] ctx_id = '0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic          mem_valid, stx_done, stx_ok, alert;
    logic [2:0]    mem_op;
    logic [AW-1:0] mem_addr;
    logic [CW-1:0] alert_ctx;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    bit          m_flag;
    logic [AW-1:0] m_addr;
    int          m_cnt;
    int          m_ph;

    excl_monitor #(.ADDR_W(AW), .CTX_W(CW), .CNT_W(NW), .ALERT_PERIOD(PER)) dut (
        .clk(clk), .rst(rst), .ctx_id(ctx_id), .req_valid(req_valid),
        .req_op(req_op), .req_addr(req_addr), .mem_valid(mem_valid),
        .mem_op(mem_op), .mem_addr(mem_addr), .stx_done(stx_done),
        .stx_ok(stx_ok), .alert(alert), .alert_ctx(alert_ctx)
    );

    always #10 clk = ~clk;

    function automatic bit model_hit(logic [AW-1:0] a);
        return m_flag && (a[AW-1:4] == m_addr[AW-1:4]);
    endfunction

    function automatic bit model_issue(bit v, logic [2:0] op, bit h);
        if (!v) return 0;
        if (op == 3'd3) return h;
        return (op == 3'd0) || (op == 3'd1) || (op == 3'd2) || (op == 3'd4);
    endfunction

    task automatic check(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [2:0] op, input logic [AW-1:0] a, input string tag);
        bit h, e_mv, e_done, e_ok, e_al;
        logic [CW-1:0] c;
        c = CW'($urandom);
        req_valid = v; req_op = op; req_addr = a; ctx_id = c;
        h      = model_hit(a);
        e_mv   = model_issue(v, op, h);
        e_done = v && (op == 3'd3);
        e_ok   = e_done && h;
        e_al   = 0;
        if (e_done && !h && m_cnt != MAXC) begin
            m_cnt++;
            m_ph++;
            if (m_ph == PER) begin e_al = 1; m_ph = 0; end
        end else if (e_ok) begin
            m_cnt = 0; m_ph = 0;
        end
        if (v && op == 3'd2) begin m_flag = 1; m_addr = a; end
        else if (v && (op == 3'd3 || op == 3'd5)) m_flag = 0;
        @(negedge clk);
        check(tag, "mem_valid", AW'(mem_valid), AW'(e_mv));
        if (e_mv) begin
            check(tag, "mem_op", AW'(mem_op), AW'(op));
            check(tag, "mem_addr", mem_addr, a);
        end
        check(tag, "stx_done", AW'(stx_done), AW'(e_done));
        if (e_done) check(tag, "stx_ok", AW'(stx_ok), AW'(e_ok));
        check(tag, "alert", AW'(alert), AW'(e_al));
        if (e_al) check(tag, "alert_ctx", AW'(alert_ctx), AW'(c));
    endtask

    localparam logic [AW-1:0] A = 32'h1234_5670;
    localparam logic [AW-1:0] B = 32'h1234_5680;

    initial begin
        void'($urandom(32'd4242));
        m_flag = 0; m_addr = '0; m_cnt = 0; m_ph = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state of outputs
        check("R1", "mem_valid", AW'(mem_valid), '0);
        check("R1", "stx_done", AW'(stx_done), '0);
        check("R1", "alert", AW'(alert), '0);
        step(1, 3'd3, '0, "R1");
        // R2 / R3: granule match ignores low nibble
        step(1, 3'd2, A | 32'h8, "R2");
        step(1, 3'd3, A | 32'hF, "R3");
        step(1, 3'd3, A, "R3");
        // R4: mismatch fails and drops the reservation
        step(1, 3'd2, A, "R4");
        step(1, 3'd3, B, "R4");
        step(1, 3'd3, A, "R4");
        // R5: swap bypasses and keeps reservation
        step(1, 3'd2, A, "R5");
        step(1, 3'd4, B, "R5");
        step(1, 3'd3, A, "R5");
        // R6: clear command
        step(1, 3'd2, A, "R6");
        step(1, 3'd5, A, "R6");
        step(1, 3'd3, A, "R6");
        // R7: plain traffic passes through
        step(1, 3'd2, A, "R7");
        step(1, 3'd0, B, "R7");
        step(1, 3'd1, A, "R7");
        step(1, 3'd3, A, "R7");
        // R8: newer reservation wins
        step(1, 3'd2, A, "R8");
        step(1, 3'd2, B, "R8");
        step(1, 3'd3, A, "R8");
        step(1, 3'd2, A, "R8");
        step(1, 3'd2, B, "R8");
        step(1, 3'd3, B, "R8");
        // R11: idle and reserved opcodes
        step(0, 3'd0, A, "R11");
        step(1, 3'd6, A, "R11");
        step(1, 3'd7, B, "R11");
        // R9 / R10: alerts every PER failures, then saturation
        for (int i = 0; i < MAXC + 6; i++) step(1, 3'd3, A, (i < MAXC) ? "R9" : "R10");
        step(1, 3'd2, A, "R9");
        step(1, 3'd3, A, "R9");
        for (int i = 0; i < PER + 1; i++) step(1, 3'd3, B, "R9");
        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] ad;
            logic [2:0] op;
            ad = (($urandom_range(0, 2) == 0) ? A : B) | AW'($urandom_range(0, 15));
            op = ($urandom_range(0, 3) == 0) ? 3'd2 : 3'($urandom_range(0, 7));
            step($urandom_range(0, 7) != 0, op, ad, "R11");
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule